// File: doc/BRIEF.md
# AXI write transaction reconstructor

A passive observer on the three write channels of an AXI port: write address, write data and write response. It drives nothing on the bus. It samples a beat only when both the valid and the ready of that channel are high. From these beats it rebuilds each write as a single record, and presents that record on a valid/ready output port.

An accepted address beat opens a context. Data beats carry no ID, so they fill the contexts in the order their addresses were accepted. A response closes the oldest data-complete context whose ID matches the response ID. The contexts form a shared pool that keeps age order. Because of this, writes with the same ID finish in order and writes with different IDs finish independently.

The record does not keep the full payload. It keeps a beat count and an XOR signature of the strobed data. A sticky error flag is raised when reconstruction cannot continue, a full flag is raised when the pool is exhausted, and a sticky overflow flag is raised when the output queue must drop a record. The block never back-pressures the bus.

Top module: `axi_wr_recon`

## Requirements
- R1: A beat on any channel is taken only in a cycle where that channel's valid and ready are both high. A beat with valid high and ready low, or with ready high and valid low, changes no record and no flag.
- R2: While rst_ni is low nothing is sampled. After reset rec_valid_o, full_o, err_o and ovf_o are 0, and traffic driven during reset produces no record and no error.
- R3: An accepted address beat opens a context. The record for that write reports the address beat's ID, address, length, size and burst fields on rec_id_o, rec_addr_o, rec_len_o, rec_size_o and rec_burst_o.
- R4: Each accepted data beat belongs to the oldest open write whose data phase has not ended, in address-acceptance order. A data beat accepted in the same cycle as an address beat goes to an older open write if one exists; otherwise it goes to the new write.
- R5: rec_beats_o is the number of data beats accepted for the write. rec_sig_o is the XOR of every accepted data word ANDed with a byte mask, where strobe bit k enables data bits 8k+7..8k.
- R6: An accepted response closes the oldest data-complete context whose ID equals b_id_i, and the record carries b_resp_i on rec_resp_o. Same-ID writes emit records in address order. Different-ID writes emit records in response order.
- R7: Records leave in completion order through a 4-entry queue. A record stays on the outputs with rec_valid_o high until a cycle in which rec_ready_i is high.
- R8: An accepted data beat with no open write waiting for data sets err_o. err_o stays set until reset.
- R9: err_o is set when the last flag disagrees with the beat position: last on beat n with n not equal to length+1, or beat length+1 accepted without last.
- R10: An accepted response with no data-complete context of its ID sets err_o and emits no record.
- R11: full_o is 1 exactly when 8 contexts are open. An address beat accepted while full opens nothing, so a later response for its ID sets err_o.
- R12: A record that completes while the queue holds 4 records and rec_ready_i is low is dropped and ovf_o is set. ovf_o stays set until reset. The queued records are kept intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| aw_valid_i | input | 1 | Observed address valid |
| aw_ready_i | input | 1 | Observed address ready |
| aw_id_i | input | ID_W | Address beat ID |
| aw_addr_i | input | ADDR_W | Start address |
| aw_len_i | input | 8 | Beats minus one |
| aw_size_i | input | 3 | Beat size code |
| aw_burst_i | input | 2 | Burst type code |
| w_valid_i | input | 1 | Observed data valid |
| w_ready_i | input | 1 | Observed data ready |
| w_data_i | input | DATA_W | Data word |
| w_strb_i | input | DATA_W/8 | Byte strobes |
| w_last_i | input | 1 | Last beat of burst |
| b_valid_i | input | 1 | Observed response valid |
| b_ready_i | input | 1 | Observed response ready |
| b_id_i | input | ID_W | Response ID |
| b_resp_i | input | 2 | Response code |
| rec_valid_o | output | 1 | Record available |
| rec_ready_i | input | 1 | Consumer takes record |
| rec_id_o | output | ID_W | Record ID |
| rec_addr_o | output | ADDR_W | Record start address |
| rec_len_o | output | 8 | Record length field |
| rec_size_o | output | 3 | Record size field |
| rec_burst_o | output | 2 | Record burst field |
| rec_beats_o | output | 9 | Counted data beats |
| rec_resp_o | output | 2 | Response code |
| rec_sig_o | output | DATA_W | Strobed data XOR signature |
| full_o | output | 1 | All contexts in use |
| err_o | output | 1 | Sticky reconstruction error |
| ovf_o | output | 1 | Sticky record drop |

## Verification
The bench builds the block with its defaults: 4-bit IDs, 32-bit data, 8 contexts and a 4-record output queue. Eight contexts let a short sequence of eight address beats make full_o observable and show that a ninth write is discarded. A 4-deep queue lets a fifth record, arriving while the consumer stalls, show the overflow drop. The 4-bit ID space leaves room for out-of-order completion across several IDs and for in-order completion of back-to-back writes that share an ID.

// File: rtl/axi_wr_recon_pkg.sv
package axi_wr_recon_pkg;
  // protocol-fixed field widths
  localparam int unsigned LEN_W   = 8;
  localparam int unsigned SIZE_W  = 3;
  localparam int unsigned BURST_W = 2;
  localparam int unsigned RESP_W  = 2;
  localparam int unsigned CNT_W   = LEN_W + 1;
endpackage

// File: rtl/oldest_pick.sv
module oldest_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned RW = 4,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  cand_i,
  input  logic [RW-1:0] rank_i [N],
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  logic [RW-1:0] best;

  // lowest rank = oldest; ranks of live slots are unique
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    best  = '1;
    for (int i = 0; i < int'(N); i++) begin
      if (cand_i[i] && (!hit_o || rank_i[i] < best)) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
        best  = rank_i[i];
      end
    end
  end
endmodule

// File: rtl/wr_rec_fifo.sv
module wr_rec_fifo #(
  parameter int unsigned W = 8,
  parameter int unsigned D = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o,
  output logic         ovf_o
);
  localparam int unsigned PW = (D > 1) ? $clog2(D) : 1;
  localparam int unsigned CW = $clog2(D + 1);

  logic [W-1:0]  mem [D];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          full, pop, acc;

  assign full    = (cnt_q == CW'(D));
  assign valid_o = (cnt_q != '0);
  assign pop     = valid_o & ready_i;
  assign acc     = push_i & (~full | pop);
  assign data_o  = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (acc) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (acc) wr_q <= (wr_q == PW'(D - 1)) ? '0 : wr_q + 1'b1;
      if (pop) rd_q <= (rd_q == PW'(D - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(acc) - CW'(pop);
      if (push_i && full && !pop) ovf_o <= 1'b1;
    end
  end

  // R7
  rec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));
  // R12
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R12
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(push_i && full && !ready_i));
endmodule

// File: rtl/axi_wr_recon.sv
module axi_wr_recon
  import axi_wr_recon_pkg::*;
#(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CTX_N  = 8,
  parameter int unsigned FIFO_D = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                aw_valid_i,
  input  logic                aw_ready_i,
  input  logic [ID_W-1:0]     aw_id_i,
  input  logic [ADDR_W-1:0]   aw_addr_i,
  input  logic [LEN_W-1:0]    aw_len_i,
  input  logic [SIZE_W-1:0]   aw_size_i,
  input  logic [BURST_W-1:0]  aw_burst_i,
  input  logic                w_valid_i,
  input  logic                w_ready_i,
  input  logic [DATA_W-1:0]   w_data_i,
  input  logic [DATA_W/8-1:0] w_strb_i,
  input  logic                w_last_i,
  input  logic                b_valid_i,
  input  logic                b_ready_i,
  input  logic [ID_W-1:0]     b_id_i,
  input  logic [RESP_W-1:0]   b_resp_i,
  output logic                rec_valid_o,
  input  logic                rec_ready_i,
  output logic [ID_W-1:0]     rec_id_o,
  output logic [ADDR_W-1:0]   rec_addr_o,
  output logic [LEN_W-1:0]    rec_len_o,
  output logic [SIZE_W-1:0]   rec_size_o,
  output logic [BURST_W-1:0]  rec_burst_o,
  output logic [CNT_W-1:0]    rec_beats_o,
  output logic [RESP_W-1:0]   rec_resp_o,
  output logic [DATA_W-1:0]   rec_sig_o,
  output logic                full_o,
  output logic                err_o,
  output logic                ovf_o
);
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned RANK_W = $clog2(CTX_N + 1);
  localparam int unsigned IDX_W  = (CTX_N > 1) ? $clog2(CTX_N) : 1;
  localparam int unsigned REC_W  = ID_W + ADDR_W + LEN_W + SIZE_W + BURST_W
                                 + CNT_W + RESP_W + DATA_W;

  logic [CTX_N-1:0]   slot_v, slot_done;
  logic [ID_W-1:0]    slot_id    [CTX_N];
  logic [ADDR_W-1:0]  slot_addr  [CTX_N];
  logic [LEN_W-1:0]   slot_len   [CTX_N];
  logic [SIZE_W-1:0]  slot_size  [CTX_N];
  logic [BURST_W-1:0] slot_burst [CTX_N];
  logic [CNT_W-1:0]   slot_beats [CTX_N];
  logic [DATA_W-1:0]  slot_sig   [CTX_N];
  logic [RANK_W-1:0]  slot_rank  [CTX_N];

  logic aw_fire, w_fire, b_fire;
  assign aw_fire = aw_valid_i & aw_ready_i;
  assign w_fire  = w_valid_i & w_ready_i;
  assign b_fire  = b_valid_i & b_ready_i;

  // strobed data word
  logic [DATA_W-1:0] w_mask, w_word;
  for (genvar k = 0; k < int'(STRB_W); k++) begin : g_mask
    assign w_mask[8*k +: 8] = {8{w_strb_i[k]}};
  end
  assign w_word = w_data_i & w_mask;

  // free slot search
  logic             free_hit;
  logic [IDX_W-1:0] free_idx;
  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    for (int i = 0; i < int'(CTX_N); i++) begin
      if (!slot_v[i] && !free_hit) begin
        free_hit = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // oldest data-open slot and oldest matching data-done slot
  logic [CTX_N-1:0] w_cand, b_cand;
  logic             w_hit, b_hit;
  logic [IDX_W-1:0] w_idx, b_idx;
  for (genvar i = 0; i < int'(CTX_N); i++) begin : g_cand
    assign w_cand[i] = slot_v[i] & ~slot_done[i];
    assign b_cand[i] = slot_v[i] & slot_done[i] & (slot_id[i] == b_id_i);
  end

  oldest_pick #(.N(CTX_N), .RW(RANK_W), .IW(IDX_W)) u_w_pick (
    .cand_i(w_cand), .rank_i(slot_rank), .hit_o(w_hit), .idx_o(w_idx));
  oldest_pick #(.N(CTX_N), .RW(RANK_W), .IW(IDX_W)) u_b_pick (
    .cand_i(b_cand), .rank_i(slot_rank), .hit_o(b_hit), .idx_o(b_idx));

  logic aw_take, w_to_old, w_to_new, w_orphan, b_close, b_orphan, w_bad;
  assign aw_take  = aw_fire & free_hit;
  assign w_to_old = w_fire & w_hit;
  assign w_to_new = w_fire & ~w_hit & aw_take;
  assign w_orphan = w_fire & ~w_hit & ~aw_take;
  assign b_close  = b_fire & b_hit;
  assign b_orphan = b_fire & ~b_hit;

  logic [CNT_W-1:0] w_cnt;
  logic [LEN_W-1:0] w_len;
  assign w_cnt = (w_hit ? slot_beats[w_idx] : '0) + CNT_W'(1);
  assign w_len = w_hit ? slot_len[w_idx] : aw_len_i;
  assign w_bad = (w_to_old | w_to_new)
               & (w_last_i != (w_cnt == ({1'b0, w_len} + CNT_W'(1))));

  logic [RANK_W-1:0] n_live;
  assign n_live = RANK_W'($countones(slot_v));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_v    <= '0;
      slot_done <= '0;
      err_o     <= 1'b0;
      for (int i = 0; i < int'(CTX_N); i++) begin
        slot_id[i]    <= '0;
        slot_addr[i]  <= '0;
        slot_len[i]   <= '0;
        slot_size[i]  <= '0;
        slot_burst[i] <= '0;
        slot_beats[i] <= '0;
        slot_sig[i]   <= '0;
        slot_rank[i]  <= '0;
      end
    end else begin
      if (w_orphan || w_bad || b_orphan) err_o <= 1'b1;
      for (int i = 0; i < int'(CTX_N); i++) begin
        if (b_close && IDX_W'(i) == b_idx)
          slot_v[i] <= 1'b0;
        else if (b_close && slot_v[i] && slot_rank[i] > slot_rank[b_idx])
          slot_rank[i] <= slot_rank[i] - 1'b1;
        if (w_to_old && IDX_W'(i) == w_idx) begin
          slot_beats[i] <= w_cnt;
          slot_sig[i]   <= slot_sig[i] ^ w_word;
          if (w_last_i) slot_done[i] <= 1'b1;
        end
        if (aw_take && IDX_W'(i) == free_idx) begin
          slot_v[i]     <= 1'b1;
          slot_done[i]  <= w_to_new & w_last_i;
          slot_id[i]    <= aw_id_i;
          slot_addr[i]  <= aw_addr_i;
          slot_len[i]   <= aw_len_i;
          slot_size[i]  <= aw_size_i;
          slot_burst[i] <= aw_burst_i;
          slot_beats[i] <= w_to_new ? CNT_W'(1) : '0;
          slot_sig[i]   <= w_to_new ? w_word : '0;
          slot_rank[i]  <= n_live - RANK_W'(b_close);
        end
      end
    end
  end

  assign full_o = &slot_v;

  logic [REC_W-1:0] rec_in, rec_out;
  assign rec_in = {slot_id[b_idx], slot_addr[b_idx], slot_len[b_idx],
                   slot_size[b_idx], slot_burst[b_idx], slot_beats[b_idx],
                   b_resp_i, slot_sig[b_idx]};

  wr_rec_fifo #(.W(REC_W), .D(FIFO_D)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (b_close),
    .data_i  (rec_in),
    .valid_o (rec_valid_o),
    .ready_i (rec_ready_i),
    .data_o  (rec_out),
    .ovf_o   (ovf_o)
  );

  assign {rec_id_o, rec_addr_o, rec_len_o, rec_size_o, rec_burst_o,
          rec_beats_o, rec_resp_o, rec_sig_o} = rec_out;

  logic [CTX_N-1:0] head_vec;
  for (genvar i = 0; i < int'(CTX_N); i++) begin : g_head
    assign head_vec[i] = slot_v[i] && (slot_rank[i] == '0);
  end

  // R1
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aw_fire && !b_fire |=> $stable(slot_v));
  // R3
  open_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_fire && !full_o && !b_close
      |=> $countones(slot_v) == $past($countones(slot_v)) + 1);
  // R11
  full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_fire && full_o && !b_fire |=> $stable(slot_v));
  // R6
  one_oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(head_vec));
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: tb/axi_wr_recon_test.sv
`timescale 1ns/1ps
module axi_wr_recon_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aw_valid = 0, aw_ready = 0, w_valid = 0, w_ready = 0, w_last = 0;
  logic        b_valid = 0, b_ready = 0, rec_ready = 1;
  logic [3:0]  aw_id = 0, b_id = 0;
  logic [31:0] aw_addr = 0, w_data = 0;
  logic [7:0]  aw_len = 0;
  logic [2:0]  aw_size = 0;
  logic [1:0]  aw_burst = 0, b_resp = 0;
  logic [3:0]  w_strb = 0;
  logic        rec_valid, full, err, ovf;
  logic [3:0]  rec_id;
  logic [31:0] rec_addr, rec_sig;
  logic [7:0]  rec_len;
  logic [2:0]  rec_size;
  logic [1:0]  rec_burst, rec_resp;
  logic [8:0]  rec_beats;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  axi_wr_recon uut (
    .clk_i(clk), .rst_ni(rst_n),
    .aw_valid_i(aw_valid), .aw_ready_i(aw_ready), .aw_id_i(aw_id),
    .aw_addr_i(aw_addr), .aw_len_i(aw_len), .aw_size_i(aw_size),
    .aw_burst_i(aw_burst),
    .w_valid_i(w_valid), .w_ready_i(w_ready), .w_data_i(w_data),
    .w_strb_i(w_strb), .w_last_i(w_last),
    .b_valid_i(b_valid), .b_ready_i(b_ready), .b_id_i(b_id), .b_resp_i(b_resp),
    .rec_valid_o(rec_valid), .rec_ready_i(rec_ready), .rec_id_o(rec_id),
    .rec_addr_o(rec_addr), .rec_len_o(rec_len), .rec_size_o(rec_size),
    .rec_burst_o(rec_burst), .rec_beats_o(rec_beats), .rec_resp_o(rec_resp),
    .rec_sig_o(rec_sig), .full_o(full), .err_o(err), .ovf_o(ovf)
  );

  typedef struct packed {
    logic [3:0]  id;
    logic [31:0] addr;
    logic [7:0]  len;
    logic [2:0]  size;
    logic [1:0]  burst;
    logic [8:0]  beats;
    logic [1:0]  resp;
    logic [31:0] sig;
  } rec_t;
  rec_t got[$];

  always @(posedge clk)
    if (rst_n && rec_valid && rec_ready)
      got.push_back({rec_id, rec_addr, rec_len, rec_size, rec_burst,
                     rec_beats, rec_resp, rec_sig});

  function automatic logic [31:0] sm(input logic [31:0] d, input logic [3:0] s);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{s[k]}};
    return d & m;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rec(input int n, input string req, input logic [3:0] id,
                         input logic [31:0] addr, input logic [7:0] len,
                         input logic [8:0] beats, input logic [1:0] resp,
                         input logic [31:0] sig);
    rec_t r;
    if (n >= got.size()) begin
      chk(1'b0, req, got.size(), n + 1);
      return;
    end
    r = got[n];
    chk(r.id == id, req, r.id, id);
    chk(r.addr == addr, req, r.addr, addr);
    chk(r.len == len && r.size == 3'd2 && r.burst == 2'd1, req,
        {r.len, r.size, r.burst}, {len, 3'd2, 2'd1});
    chk(r.beats == beats, req, r.beats, beats);
    chk(r.resp == resp, req, r.resp, resp);
    chk(r.sig == sig, req, r.sig, sig);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready} = '0;
    rec_ready = 1'b1;
    repeat (2) @(negedge clk);
    got.delete();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic aw_put(input logic [3:0] id, input logic [31:0] addr, input logic [7:0] len);
    @(negedge clk);
    aw_valid = 1; aw_ready = 1; aw_id = id; aw_addr = addr; aw_len = len;
    aw_size = 3'd2; aw_burst = 2'd1;
    @(negedge clk);
    aw_valid = 0; aw_ready = 0;
  endtask

  task automatic w_put(input logic [31:0] d, input logic [3:0] s, input logic l);
    @(negedge clk);
    w_valid = 1; w_ready = 1; w_data = d; w_strb = s; w_last = l;
    @(negedge clk);
    w_valid = 0; w_ready = 0; w_last = 0;
  endtask

  task automatic b_put(input logic [3:0] id, input logic [1:0] r);
    @(negedge clk);
    b_valid = 1; b_ready = 1; b_id = id; b_resp = r;
    @(negedge clk);
    b_valid = 0; b_ready = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // R2: reset state, traffic during reset ignored
  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    aw_valid = 1; aw_ready = 1; aw_id = 1; aw_len = 0;
    w_valid = 1; w_ready = 1; w_last = 1; b_valid = 1; b_ready = 1; b_id = 1;
    repeat (2) @(negedge clk);
    {aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready} = '0;
    got.delete();
    rst_n = 1'b1;
    settle();
    chk(!rec_valid && !full && !err && !ovf, "R2 reset state",
        {rec_valid, full, err, ovf}, 0);
    chk(got.size() == 0, "R2 no record from reset traffic", got.size(), 0);
  endtask

  // R3 R4 R5 R7: one 4-beat write with mixed strobes
  task automatic t_single();
    logic [31:0] s;
    do_reset();
    aw_put(4'd3, 32'h0000_1000, 8'd3);
    w_put(32'hA5A5_0001, 4'hF, 0);
    w_put(32'h1234_5678, 4'h3, 0);
    w_put(32'hFFFF_0000, 4'hC, 0);
    w_put(32'h0F0F_0F0F, 4'h0, 1);
    s = sm(32'hA5A5_0001, 4'hF) ^ sm(32'h1234_5678, 4'h3)
      ^ sm(32'hFFFF_0000, 4'hC);
    chk(got.size() == 0 && !rec_valid, "R6 no record before response", got.size(), 0);
    b_put(4'd3, 2'd0);
    settle();
    chk(got.size() == 1, "R7 one record", got.size(), 1);
    chk_rec(0, "R3 R5 single write fields", 4'd3, 32'h1000, 8'd3, 9'd4, 2'd0, s);
    chk(!err, "R9 correct last gives no error", err, 0);
  endtask

  // R1: stalled beats on every channel are ignored
  task automatic t_stall();
    do_reset();
    @(negedge clk);
    aw_valid = 1; aw_ready = 0; aw_id = 7; aw_addr = 32'hDEAD_0000; aw_len = 8'd9;
    w_valid = 0; w_ready = 1; w_data = 32'hFFFF_FFFF; w_strb = 4'hF; w_last = 1;
    b_valid = 1; b_ready = 0; b_id = 7;
    repeat (3) @(negedge clk);
    {aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready} = '0;
    settle();
    chk(!err && got.size() == 0 && !full, "R1 stalled beats ignored",
        {err, full}, 0);
    aw_put(4'd7, 32'h0000_2000, 8'd1);
    @(negedge clk);
    w_valid = 1; w_ready = 0; w_data = 32'h1111_1111; w_strb = 4'hF;
    repeat (2) @(negedge clk);
    w_valid = 0;
    w_put(32'h0000_00AA, 4'h1, 0);
    w_put(32'h0000_BB00, 4'h2, 1);
    b_put(4'd7, 2'd1);
    settle();
    chk_rec(0, "R1 stalled W not counted", 4'd7, 32'h2000, 8'd1, 9'd2, 2'd1,
            32'h0000_BBAA);
    chk(!err, "R1 no error", err, 0);
  endtask

  // R6: different IDs out of order, same ID in order
  task automatic t_order();
    do_reset();
    aw_put(4'd1, 32'h100, 8'd0);
    aw_put(4'd2, 32'h200, 8'd0);
    w_put(32'h0000_0011, 4'hF, 1);
    w_put(32'h0000_0022, 4'hF, 1);
    b_put(4'd2, 2'd0);
    b_put(4'd1, 2'd3);
    aw_put(4'd5, 32'h500, 8'd0);
    aw_put(4'd5, 32'h504, 8'd0);
    w_put(32'h0000_0055, 4'hF, 1);
    w_put(32'h0000_0066, 4'hF, 1);
    b_put(4'd5, 2'd0);
    b_put(4'd5, 2'd2);
    settle();
    chk(got.size() == 4, "R6 four records", got.size(), 4);
    chk_rec(0, "R6 id2 first", 4'd2, 32'h200, 8'd0, 9'd1, 2'd0, 32'h22);
    chk_rec(1, "R6 id1 second", 4'd1, 32'h100, 8'd0, 9'd1, 2'd3, 32'h11);
    chk_rec(2, "R6 same id older", 4'd5, 32'h500, 8'd0, 9'd1, 2'd0, 32'h55);
    chk_rec(3, "R6 same id newer", 4'd5, 32'h504, 8'd0, 9'd1, 2'd2, 32'h66);
    chk(!err, "R6 no error", err, 0);
  endtask

  // R4: data beat in the same cycle as an address beat
  task automatic t_same_cycle();
    do_reset();
    @(negedge clk);
    aw_valid = 1; aw_ready = 1; aw_id = 4'd8; aw_addr = 32'h800; aw_len = 8'd0;
    aw_size = 3'd2; aw_burst = 2'd1;
    w_valid = 1; w_ready = 1; w_data = 32'h88; w_strb = 4'hF; w_last = 1;
    @(negedge clk);
    aw_id = 4'd9; aw_addr = 32'h900; w_valid = 0; w_ready = 0; w_last = 0;
    @(negedge clk);
    // older id9 waits for data while id10 address and id9 data coincide
    aw_id = 4'd10; aw_addr = 32'hA00;
    w_valid = 1; w_ready = 1; w_data = 32'h99; w_last = 1;
    @(negedge clk);
    aw_valid = 0; aw_ready = 0;
    w_data = 32'hAA;
    @(negedge clk);
    w_valid = 0; w_ready = 0; w_last = 0;
    b_put(4'd10, 2'd0);
    b_put(4'd9, 2'd0);
    b_put(4'd8, 2'd0);
    settle();
    chk_rec(0, "R4 new-write data id10", 4'd10, 32'hA00, 8'd0, 9'd1, 2'd0, 32'hAA);
    chk_rec(1, "R4 older-write data id9", 4'd9, 32'h900, 8'd0, 9'd1, 2'd0, 32'h99);
    chk_rec(2, "R4 same-cycle data id8", 4'd8, 32'h800, 8'd0, 9'd1, 2'd0, 32'h88);
    chk(!err, "R4 no error", err, 0);
  endtask

  // R8 R9 R10: reconstruction errors
  task automatic t_errors();
    do_reset();
    w_put(32'h1, 4'hF, 1);
    chk(err == 1'b1, "R8 data with no address", err, 1);
    chk(got.size() == 0, "R8 no record", got.size(), 0);
    do_reset();
    aw_put(4'd2, 32'h0, 8'd1);
    w_put(32'h1, 4'hF, 1);
    chk(err == 1'b1, "R9 early last", err, 1);
    do_reset();
    aw_put(4'd2, 32'h0, 8'd0);
    w_put(32'h1, 4'hF, 0);
    chk(err == 1'b1, "R9 missing last", err, 1);
    do_reset();
    aw_put(4'd4, 32'h0, 8'd0);
    b_put(4'd4, 2'd0);
    settle();
    chk(err == 1'b1 && got.size() == 0, "R10 response before data", err, 1);
    do_reset();
    b_put(4'd6, 2'd0);
    chk(err == 1'b1, "R10 response with unknown id", err, 1);
    do_reset();
    chk(err == 1'b0, "R2 reset clears error", err, 0);
  endtask

  // R11: capacity exhaustion
  task automatic t_full();
    do_reset();
    for (int i = 0; i < 8; i++) aw_put(4'(i), 32'(i * 16), 8'd0);
    chk(full == 1'b1, "R11 full at eight", full, 1);
    aw_put(4'd9, 32'hFFF0, 8'd0);
    chk(full == 1'b1 && !err, "R11 address while full", {full, err}, 2);
    for (int i = 0; i < 8; i++) w_put(32'(i + 1), 4'hF, 1);
    for (int i = 0; i < 8; i++) b_put(4'(i), 2'd0);
    settle();
    chk(full == 1'b0 && got.size() == 8, "R11 drained", got.size(), 8);
    chk_rec(7, "R11 last record", 4'd7, 32'h70, 8'd0, 9'd1, 2'd0, 32'h8);
    b_put(4'd9, 2'd0);
    settle();
    chk(err == 1'b1 && got.size() == 8, "R11 dropped write has no context", err, 1);
  endtask

  // R7 R12: queue overflow under consumer stall
  task automatic t_ovf();
    do_reset();
    rec_ready = 1'b0;
    for (int i = 0; i < 5; i++) begin
      aw_put(4'(i), 32'(i * 4), 8'd0);
      w_put(32'(i + 16), 4'hF, 1);
      b_put(4'(i), 2'd0);
      if (i == 3) chk(!ovf && rec_valid, "R12 four records fit", ovf, 0);
    end
    chk(ovf == 1'b1, "R12 overflow set", ovf, 1);
    chk(rec_valid && rec_id == 4'd0, "R7 head record held", rec_id, 0);
    rec_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk(got.size() == 4, "R12 four kept", got.size(), 4);
    chk_rec(3, "R12 queued record intact", 4'd3, 32'hC, 8'd0, 9'd1, 2'd0, 32'd19);
    chk(ovf == 1'b1 && !err, "R12 overflow sticky", {ovf, err}, 2);
  endtask

  initial begin
    t_reset();
    t_single();
    t_stall();
    t_order();
    t_same_cycle();
    t_errors();
    t_full();
    t_ovf();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule